// File: doc/BRIEF.md
# Pipelined Request Issuer with Error Retry

This block is the request side of an agent on a split-transaction system bus. Transactions arrive from a local queue through a valid/ready handshake. The block asks for the request bus and waits for the grant before it drives anything. It then sends each request over two consecutive clocks. The first clock carries the 36-bit address and the memory type. The second clock carries an internal transaction tag, the request length and the byte enables for the 64-bit data path.

Each request is given a tag from a pool of eight. The tag stays in use until the response for it retires, so at most eight transactions can be in flight at once. When the pool is empty, the queue is not served. The bus reports a per-request error status, and the block samples it exactly three clocks after the request's first clock. On the first error, the same request is sent again with the same tag and the same fields, and it goes ahead of any new queue entry. On the second error, the block raises a sticky machine-check flag and releases the tag instead of retrying.

Top module: `req_issuer`

## Requirements
- R1: After reset, `arb_req`, `q_ready`, `rq_a_valid`, `rq_b_valid` and `mce` are 0, and `inflight` is 0.
- R2: `rq_a_valid` rises only in the clock after a clock in which both `arb_req` and `arb_gnt` were 1. While `arb_gnt` stays low, no request is driven, even if work is waiting.
- R3: Every first request clock (`rq_a_valid`=1, with `rq_addr` and `rq_mtype`) is followed in the very next clock by a second request clock (`rq_b_valid`=1, with `rq_tag`, `rq_len` and `rq_be`). The fields sent are the ones accepted from the queue.
- R4: For a request whose first clock is cycle t, `err_in` is sampled in cycle t+3 only.
- R5: A request that gets its first error is sent again with the same tag and fields. The retry is sent before any new queue entry that has not yet been accepted.
- R6: A second error on the same request sets `mce` to 1 and holds it until reset. `mce_tag` reports the tag, the tag is released, and no further retry is sent.
- R7: New transactions take the lowest-numbered free tag, where tags are 0 to 7. A tag is freed when `rsp_valid` is 1 with that value on `rsp_tag`. `inflight` counts the tags in use.
- R8: When eight tags are in use, `q_ready` stays 0 and no request is issued until a tag is freed.
- R9: If the bus is still granted and more work is waiting after a second request clock, the next first request clock follows immediately, two cycles after the previous one. If no work is waiting, `arb_req` drops.
- R10: A request that passes its error check cleanly clears that tag's error history. A later transaction on the same tag can therefore retry once more before it reaches machine check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_valid | input | 1 | Local queue holds a transaction |
| q_ready | output | 1 | Queue entry accepted this cycle |
| q_addr | input | 36 | Transaction address |
| q_mtype | input | 3 | Memory type |
| q_len | input | 2 | Request length code |
| q_be | input | 8 | Byte enables |
| arb_req | output | 1 | Request for ownership of the request bus |
| arb_gnt | input | 1 | Ownership granted |
| rq_a_valid | output | 1 | First request clock |
| rq_addr | output | 36 | Address, valid in the first clock |
| rq_mtype | output | 3 | Memory type, valid in the first clock |
| rq_b_valid | output | 1 | Second request clock |
| rq_tag | output | 3 | Transaction tag, valid in the second clock |
| rq_len | output | 2 | Length, valid in the second clock |
| rq_be | output | 8 | Byte enables, valid in the second clock |
| err_in | input | 1 | Bus error status |
| rsp_valid | input | 1 | A response has retired |
| rsp_tag | input | 3 | Tag of the retired response |
| inflight | output | 4 | Number of tags in use |
| mce | output | 1 | Sticky machine-check flag |
| mce_tag | output | 3 | Tag that caused the machine check |

## Verification
The hardest case to reach is a retry competing with new work. The error verdict lands three clocks after a request starts, and by then other requests have been sent back to back. To reach it, the bench streams four queue entries while the bus stays granted and puts an error on the first one only. It then checks that the retry is sent after the third new request and before the fourth, with its original tag.

Full occupancy is reached by filling all eight tags, then offering a ninth entry, which must wait until a chosen tag retires and must then take that tag. Tag history is checked by putting one error on a tag after that tag had an earlier error followed by a clean retry.

// File: rtl/rqi_pkg.sv
package rqi_pkg;
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ARB  = 2'd1,
        S_PA   = 2'd2,
        S_PB   = 2'd3
    } rqi_state_e;
endpackage

// File: rtl/rqi_tag_pool.sv
module rqi_tag_pool #(
    parameter int NTAG  = 8,
    parameter int TAG_W = $clog2(NTAG),
    parameter int CNT_W = $clog2(NTAG + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc,
    input  logic [NTAG-1:0]  free_mask,
    output logic             avail,
    output logic [TAG_W-1:0] alloc_tag,
    output logic [CNT_W-1:0] count
);
    typedef struct packed {
        logic [NTAG-1:0] used;
    } pool_s;

    pool_s cs_q, ns_d;

    always_comb begin
        ns_d      = cs_q;
        avail     = 1'b0;
        alloc_tag = '0;
        count     = '0;
        for (int i = NTAG - 1; i >= 0; i--) begin
            if (!cs_q.used[i]) begin
                avail     = 1'b1;
                alloc_tag = TAG_W'(i);
            end
        end
        for (int i = 0; i < NTAG; i++) begin
            count = count + CNT_W'(cs_q.used[i]);
        end
        ns_d.used = cs_q.used & ~free_mask;
        if (alloc) begin
            ns_d.used[alloc_tag] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= ns_d;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> avail); // R8
    AST_FREE_LIVE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (free_mask & ~cs_q.used) == '0); // R7
endmodule

// File: rtl/rqi_err_pipe.sv
module rqi_err_pipe #(
    parameter int ERR_DLY = 3,
    parameter int TAG_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [TAG_W-1:0] push_tag,
    input  logic             err_in,
    output logic             chk_valid,
    output logic [TAG_W-1:0] chk_tag,
    output logic             chk_err
);
    localparam int MAX_LIVE = (ERR_DLY + 1) / 2;

    typedef struct packed {
        logic [ERR_DLY-1:0]            v;
        logic [ERR_DLY-1:0][TAG_W-1:0] t;
    } pipe_s;

    pipe_s cs_q, ns_d;

    always_comb begin
        ns_d      = cs_q;
        ns_d.v[0] = push;
        ns_d.t[0] = push_tag;
        for (int i = 1; i < ERR_DLY; i++) begin
            ns_d.v[i] = cs_q.v[i-1];
            ns_d.t[i] = cs_q.t[i-1];
        end
        chk_valid = cs_q.v[ERR_DLY-1];
        chk_tag   = cs_q.t[ERR_DLY-1];
        chk_err   = cs_q.v[ERR_DLY-1] & err_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= ns_d;
    end

    AST_PUSH_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !push); // R3
    AST_WINDOW_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cs_q.v) <= MAX_LIVE); // R4
endmodule

// File: rtl/rqi_retry_ctl.sv
module rqi_retry_ctl #(
    parameter int NTAG    = 8,
    parameter int MAX_ERR = 2,
    parameter int TAG_W   = $clog2(NTAG),
    parameter int TRY_W   = $clog2(MAX_ERR + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_valid,
    input  logic [TAG_W-1:0] chk_tag,
    input  logic             chk_err,
    input  logic             take,
    input  logic [TAG_W-1:0] take_tag,
    output logic             pend_any,
    output logic [TAG_W-1:0] pend_tag,
    output logic             fatal,
    output logic [TAG_W-1:0] fatal_tag
);
    typedef struct packed {
        logic [NTAG-1:0]            pend;
        logic [NTAG-1:0][TRY_W-1:0] errs;
    } rty_s;

    rty_s cs_q, ns_d;
    logic [TRY_W-1:0] errs_next;

    always_comb begin
        ns_d      = cs_q;
        fatal     = 1'b0;
        fatal_tag = chk_tag;
        pend_any  = |cs_q.pend;
        pend_tag  = '0;
        for (int i = NTAG - 1; i >= 0; i--) begin
            if (cs_q.pend[i]) pend_tag = TAG_W'(i);
        end
        errs_next = cs_q.errs[chk_tag] + TRY_W'(1);
        if (take) begin
            ns_d.pend[take_tag] = 1'b0;
        end
        if (chk_valid) begin
            if (!chk_err) begin
                ns_d.errs[chk_tag] = '0;
            end else if (errs_next >= TRY_W'(MAX_ERR)) begin
                fatal              = 1'b1;
                ns_d.errs[chk_tag] = '0;
            end else begin
                ns_d.errs[chk_tag] = errs_next;
                ns_d.pend[chk_tag] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= ns_d;
    end

    AST_TAKE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> cs_q.pend[take_tag]); // R5
    AST_CHECK_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |-> !cs_q.pend[chk_tag]); // R5
endmodule

// File: rtl/req_issuer.sv
module req_issuer #(
    parameter int NTAG    = 8,
    parameter int ADDR_W  = 36,
    parameter int DATA_W  = 64,
    parameter int MT_W    = 3,
    parameter int LEN_W   = 2,
    parameter int ERR_DLY = 3,
    parameter int MAX_ERR = 2,
    localparam int BE_W   = DATA_W / 8,
    localparam int TAG_W  = $clog2(NTAG),
    localparam int CNT_W  = $clog2(NTAG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_valid,
    output logic              q_ready,
    input  logic [ADDR_W-1:0] q_addr,
    input  logic [MT_W-1:0]   q_mtype,
    input  logic [LEN_W-1:0]  q_len,
    input  logic [BE_W-1:0]   q_be,
    output logic              arb_req,
    input  logic              arb_gnt,
    output logic              rq_a_valid,
    output logic [ADDR_W-1:0] rq_addr,
    output logic [MT_W-1:0]   rq_mtype,
    output logic              rq_b_valid,
    output logic [TAG_W-1:0]  rq_tag,
    output logic [LEN_W-1:0]  rq_len,
    output logic [BE_W-1:0]   rq_be,
    input  logic              err_in,
    input  logic              rsp_valid,
    input  logic [TAG_W-1:0]  rsp_tag,
    output logic [CNT_W-1:0]  inflight,
    output logic              mce,
    output logic [TAG_W-1:0]  mce_tag
);
    import rqi_pkg::*;

    typedef struct packed {
        rqi_state_e                  state;
        logic [TAG_W-1:0]            tag;
        logic [ADDR_W-1:0]           addr;
        logic [MT_W-1:0]             mtype;
        logic [LEN_W-1:0]            len;
        logic [BE_W-1:0]             be;
        logic                        mce;
        logic [TAG_W-1:0]            mce_tag;
        logic [NTAG-1:0][ADDR_W-1:0] sv_addr;
        logic [NTAG-1:0][MT_W-1:0]   sv_mtype;
        logic [NTAG-1:0][LEN_W-1:0]  sv_len;
        logic [NTAG-1:0][BE_W-1:0]   sv_be;
    } iss_s;

    iss_s cs_q, ns_d;

    logic             avail;
    logic [TAG_W-1:0] alloc_tag;
    logic [NTAG-1:0]  free_mask;
    logic             chk_valid, chk_err;
    logic [TAG_W-1:0] chk_tag;
    logic             pend_any, fatal;
    logic [TAG_W-1:0] pend_tag, fatal_tag;
    logic             have_work, go, take_retry, take_new;

    rqi_tag_pool #(.NTAG(NTAG), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc     (take_new),
        .free_mask (free_mask),
        .avail     (avail),
        .alloc_tag (alloc_tag),
        .count     (inflight)
    );

    rqi_err_pipe #(.ERR_DLY(ERR_DLY), .TAG_W(TAG_W)) u_errp (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rq_a_valid),
        .push_tag  (cs_q.tag),
        .err_in    (err_in),
        .chk_valid (chk_valid),
        .chk_tag   (chk_tag),
        .chk_err   (chk_err)
    );

    rqi_retry_ctl #(.NTAG(NTAG), .MAX_ERR(MAX_ERR), .TAG_W(TAG_W)) u_rty (
        .clk       (clk),
        .rst_n     (rst_n),
        .chk_valid (chk_valid),
        .chk_tag   (chk_tag),
        .chk_err   (chk_err),
        .take      (take_retry),
        .take_tag  (pend_tag),
        .pend_any  (pend_any),
        .pend_tag  (pend_tag),
        .fatal     (fatal),
        .fatal_tag (fatal_tag)
    );

    always_comb begin
        ns_d       = cs_q;
        have_work  = pend_any | (q_valid & avail);
        go         = arb_gnt & have_work &
                     ((cs_q.state == S_ARB) | (cs_q.state == S_PB));
        take_retry = go & pend_any;
        take_new   = go & ~pend_any;
        q_ready    = take_new;

        free_mask = '0;
        if (rsp_valid) free_mask[rsp_tag] = 1'b1;
        if (fatal)     free_mask[fatal_tag] = 1'b1;

        unique case (cs_q.state)
            S_IDLE: if (have_work) ns_d.state = S_ARB;
            S_ARB: begin
                if (go)              ns_d.state = S_PA;
                else if (!have_work) ns_d.state = S_IDLE;
            end
            S_PA: ns_d.state = S_PB;
            S_PB: begin
                if (go)             ns_d.state = S_PA;
                else if (have_work) ns_d.state = S_ARB;
                else                ns_d.state = S_IDLE;
            end
            default: ns_d.state = S_IDLE;
        endcase

        if (take_retry) begin
            ns_d.tag   = pend_tag;
            ns_d.addr  = cs_q.sv_addr[pend_tag];
            ns_d.mtype = cs_q.sv_mtype[pend_tag];
            ns_d.len   = cs_q.sv_len[pend_tag];
            ns_d.be    = cs_q.sv_be[pend_tag];
        end else if (take_new) begin
            ns_d.tag                = alloc_tag;
            ns_d.addr               = q_addr;
            ns_d.mtype              = q_mtype;
            ns_d.len                = q_len;
            ns_d.be                 = q_be;
            ns_d.sv_addr[alloc_tag]  = q_addr;
            ns_d.sv_mtype[alloc_tag] = q_mtype;
            ns_d.sv_len[alloc_tag]   = q_len;
            ns_d.sv_be[alloc_tag]    = q_be;
        end

        if (fatal) begin
            ns_d.mce     = 1'b1;
            ns_d.mce_tag = fatal_tag;
        end

        arb_req    = (cs_q.state != S_IDLE);
        rq_a_valid = (cs_q.state == S_PA);
        rq_b_valid = (cs_q.state == S_PB);
        rq_addr    = rq_a_valid ? cs_q.addr  : '0;
        rq_mtype   = rq_a_valid ? cs_q.mtype : '0;
        rq_tag     = rq_b_valid ? cs_q.tag   : '0;
        rq_len     = rq_b_valid ? cs_q.len   : '0;
        rq_be      = rq_b_valid ? cs_q.be    : '0;
        mce        = cs_q.mce;
        mce_tag    = cs_q.mce_tag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= ns_d;
    end

    AST_A_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rq_a_valid) |-> $past(arb_req && arb_gnt)); // R2
    AST_B_FOLLOWS_A: assert property (@(posedge clk) disable iff (!rst_n)
        rq_a_valid |=> rq_b_valid && $stable(rq_tag) == $stable(rq_tag)
                       && !rq_a_valid); // R3
    AST_MCE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mce) |-> mce); // R6
    AST_HOLD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        q_ready |-> (inflight < CNT_W'(NTAG))); // R8
    AST_RETRY_BEFORE_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (go && pend_any) |-> !q_ready); // R5
endmodule

// File: tb/req_issuer_test.sv
`timescale 1ns/1ps
module req_issuer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        q_valid = 1'b0;
    logic        q_ready;
    logic [35:0] q_addr = '0;
    logic [2:0]  q_mtype = '0;
    logic [1:0]  q_len = '0;
    logic [7:0]  q_be = '0;
    logic        arb_req;
    logic        arb_gnt = 1'b0;
    logic        rq_a_valid, rq_b_valid;
    logic [35:0] rq_addr;
    logic [2:0]  rq_mtype, rq_tag;
    logic [1:0]  rq_len;
    logic [7:0]  rq_be;
    logic        err_in = 1'b0;
    logic        rsp_valid = 1'b0;
    logic [2:0]  rsp_tag = '0;
    logic [3:0]  inflight;
    logic        mce;
    logic [2:0]  mce_tag;

    always #2.5 clk = ~clk;

    req_issuer uut (.*);

    int vec = 0, bad = 0, cyc = 0, n = 0, pushed = 0, inject_left = 0;
    bit gnt_en = 1'b0;
    logic [3:0] err_sr = '0;
    logic [35:0] la_addr [64];
    logic [2:0]  la_mt [64], lb_tag [64];
    logic [1:0]  lb_len [64];
    logic [7:0]  lb_be [64];
    int          la_cyc [64];

    task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                       input logic [63:0] exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    // bus monitor, grant model and error injection (err in cycle t+3)
    always @(negedge clk) begin
        cyc++;
        arb_gnt <= gnt_en && arb_req;
        err_sr = {err_sr[2:0], 1'b0};
        if (rq_a_valid && n < 64) begin
            la_addr[n] = rq_addr; la_mt[n] = rq_mtype; la_cyc[n] = cyc;
            if (inject_left > 0) begin err_sr[0] = 1'b1; inject_left--; end
        end
        if (rq_b_valid && n < 64) begin
            lb_tag[n] = rq_tag; lb_len[n] = rq_len; lb_be[n] = rq_be;
            chk(la_cyc[n] == cyc - 1, "R3 second clock follows first",
                64'(cyc - la_cyc[n]), 64'd1);
            n++;
        end
        err_in <= err_sr[3];
        if (cyc > 100000) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    task automatic push(input logic [35:0] a, input logic [2:0] m,
                        input logic [1:0] l, input logic [7:0] b);
        @(negedge clk);
        q_valid = 1'b1; q_addr = a; q_mtype = m; q_len = l; q_be = b;
        forever begin
            #1;
            if (q_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        #1 q_valid = 1'b0;
        pushed++;
    endtask

    task automatic retire(input logic [2:0] t);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_tag = t;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic wait_cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; err_sr = '0; inject_left = 0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
    endtask

    function automatic logic [35:0] fa(input int i);
        return 36'h8_0000_0000 | 36'(i * 36'h0_0101_0203);
    endfunction

    initial begin
        int base, p0;
        do_reset();
        // R1 reset state
        #1;
        chk(arb_req == 0, "R1 arb_req", 64'(arb_req), 0);
        chk(q_ready == 0, "R1 q_ready", 64'(q_ready), 0);
        chk(rq_a_valid == 0 && rq_b_valid == 0, "R1 request idle",
            64'({rq_a_valid, rq_b_valid}), 0);
        chk(mce == 0, "R1 mce", 64'(mce), 0);
        chk(inflight == 0, "R1 inflight", 64'(inflight), 0);

        // R2: no request without grant
        base = n;
        fork push(36'h3_0000_0040, 3'd2, 2'd3, 8'h0F); join_none
        wait_cyc(12);
        chk(n == base, "R2 no request without grant", 64'(n), 64'(base));
        chk(arb_req == 1, "R2 ownership requested", 64'(arb_req), 1);
        gnt_en = 1'b1;
        wait_cyc(8);
        chk(n == base + 1, "R2 request after grant", 64'(n), 64'(base + 1));
        chk(la_addr[base] == 36'h3_0000_0040 && la_mt[base] == 3'd2,
            "R3 first clock fields", 64'(la_addr[base]), 64'h3_0000_0040);
        chk(lb_tag[base] == 0 && lb_len[base] == 3 && lb_be[base] == 8'h0F,
            "R3 second clock fields", 64'({lb_tag[base], lb_len[base], lb_be[base]}),
            64'({3'd0, 2'd3, 8'h0F}));
        chk(inflight == 1, "R7 inflight one", 64'(inflight), 1);
        chk(arb_req == 0, "R9 ownership released when idle", 64'(arb_req), 0);
        retire(3'd0);
        #1 chk(inflight == 0, "R7 tag freed on retire", 64'(inflight), 0);

        // R4/R5: one error -> same request again with same tag
        base = n; inject_left = 1;
        push(36'h5_5555_5550, 3'd6, 2'd1, 8'hA5);
        wait_cyc(20);
        chk(n == base + 2, "R5 one retry issued", 64'(n), 64'(base + 2));
        chk(la_addr[base + 1] == 36'h5_5555_5550 && lb_tag[base + 1] == 0 &&
            lb_be[base + 1] == 8'hA5, "R5 retry same tag and fields",
            64'(la_addr[base + 1]), 64'h5_5555_5550);
        chk(la_cyc[base + 1] - la_cyc[base] == 6, "R4 error sampled at t+3",
            64'(la_cyc[base + 1] - la_cyc[base]), 6);
        chk(mce == 0, "R5 no machine check after one error", 64'(mce), 0);
        retire(3'd0);

        // R10: clean retry cleared history, one more error only retries
        base = n; inject_left = 1;
        push(36'h1_2345_6780, 3'd1, 2'd0, 8'hFF);
        wait_cyc(20);
        chk(n == base + 2 && mce == 0, "R10 history cleared by clean issue",
            64'({n - base, mce}), 64'({32'd2, 1'b0}));
        retire(3'd0);

        // R6: two errors -> machine check, tag released
        base = n; inject_left = 2;
        push(36'h7_0000_1000, 3'd4, 2'd2, 8'h3C);
        wait_cyc(25);
        chk(n == base + 2, "R6 no third attempt", 64'(n), 64'(base + 2));
        chk(mce == 1 && mce_tag == 0, "R6 machine check raised",
            64'({mce, mce_tag}), 64'({1'b1, 3'd0}));
        chk(inflight == 0, "R6 tag released", 64'(inflight), 0);
        wait_cyc(5);
        chk(mce == 1, "R6 machine check sticky", 64'(mce), 1);

        // R7/R8/R9: fill all tags back to back
        do_reset();
        base = n;
        for (int i = 0; i < 8; i++) push(fa(i), 3'(i), 2'(i), 8'(1 << i));
        wait_cyc(6);
        chk(n == base + 8, "R7 eight issued", 64'(n), 64'(base + 8));
        for (int i = 0; i < 8; i++) begin
            chk(lb_tag[base + i] == 3'(i), "R7 lowest free tag",
                64'(lb_tag[base + i]), 64'(i));
            chk(la_addr[base + i] == fa(i) && la_mt[base + i] == 3'(i) &&
                lb_len[base + i] == 2'(i) && lb_be[base + i] == 8'(1 << i),
                "R3 fields per entry", 64'(la_addr[base + i]), 64'(fa(i)));
            if (i > 0)
                chk(la_cyc[base + i] - la_cyc[base + i - 1] == 2,
                    "R9 back-to-back issue", 64'(la_cyc[base + i] - la_cyc[base + i - 1]), 2);
        end
        chk(inflight == 8, "R8 eight in flight", 64'(inflight), 8);
        p0 = pushed;
        fork push(36'h9_9999_9990, 3'd5, 2'd1, 8'h81); join_none
        wait_cyc(20);
        chk(n == base + 8 && pushed == p0, "R8 held off when full",
            64'(n), 64'(base + 8));
        chk(arb_req == 0, "R8 no ownership request when full", 64'(arb_req), 0);
        retire(3'd5);
        wait_cyc(10);
        chk(n == base + 9 && lb_tag[base + 8] == 5, "R7 freed tag reused",
            64'(lb_tag[base + 8]), 5);
        chk(inflight == 8, "R7 count after reuse", 64'(inflight), 8);
        for (int i = 0; i < 8; i++) retire(3'(i));
        #1 chk(inflight == 0, "R7 all retired", 64'(inflight), 0);

        // R5: retry goes ahead of queued work; expected tags 0,1,2,0,3
        base = n; inject_left = 1;
        push(fa(20), 3'd0, 2'd0, 8'h01);
        push(fa(21), 3'd1, 2'd1, 8'h02);
        push(fa(22), 3'd2, 2'd2, 8'h04);
        push(fa(23), 3'd3, 2'd3, 8'h08);
        wait_cyc(12);
        chk(n == base + 5, "R5 five requests", 64'(n), 64'(base + 5));
        chk(lb_tag[base + 3] == 0 && la_addr[base + 3] == fa(20),
            "R5 retry before newer entry", 64'(la_addr[base + 3]), 64'(fa(20)));
        chk(lb_tag[base + 4] == 3 && la_addr[base + 4] == fa(23),
            "R5 new entry after retry", 64'(lb_tag[base + 4]), 3);
        chk(mce == 0, "R5 no machine check", 64'(mce), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule